// File: doc/BRIEF.md
# Descriptor-chain DMA mover

This block copies data between a local memory and a host memory. It walks a chain of transfer descriptors that sit in host memory. Software picks a direction with a command word. A read transfer moves data from host to local memory and a write transfer moves data from local to host memory. Before the command, software loads an enable mask and the host address of the first descriptor of each chain. For each descriptor the engine fetches three consecutive words into its link registers, then copies the described span one 32-bit word at a time. It then moves to the next descriptor, which sits 12 bytes further on, and stops at the descriptor whose length word has its top bit set.

Both directions share one copy datapath. A start for one direction while the other is running is queued, and it is served when the running chain ends. Each direction shows a busy flag. Three sticky error flags are shown next to them: a read error, a write error and a chain error. A finished chain pulses a done interrupt and an abandoned chain pulses an error interrupt. Both memories are reached through a simple request/acknowledge port. A request is held, with a stable address, until the acknowledge arrives, and read data is valid with the acknowledge.

Top module: `sg_dma`

## Requirements
- R1: After reset the status is zero, no memory request is raised and neither interrupt is pulsed.
- R2: Register select 0 is the command word: 0 cancels, 1 starts the read chain, 2 starts the write chain, 4 stops. A start sets that direction's busy bit (status bit 0 for read, bit 1 for write) on the next cycle only when its enable bit is set (register select 2, bit 0 for read, bit 1 for write). A start for a disabled direction is ignored: busy stays clear and no memory access occurs.
- R3: A write-chain descriptor is three words at the descriptor address plus 0, 4 and 8: local address, host address, length in bytes. The engine copies length/4 words from local to host memory. A descriptor that is not last is followed by the next one at the descriptor address plus 12. The first descriptor's address comes from register select 4.
- R4: A read-chain descriptor holds host address, local address and length, in that order. It copies host to local memory, and its first descriptor's address comes from register select 3.
- R5: Bit 31 of the length word marks the last descriptor. When its final word has been written, the busy bit clears and irq_done_o pulses for one cycle.
- R6: The write chain may hold at most 8 descriptors and the read chain only 1. A descriptor that ends without bit 31 set and has no slot left after it sets the chain error (status bit 4), clears that direction's busy bit and pulses irq_err_o.
- R7: A length of zero sets the chain error (status bit 4), moves no data, clears that direction's busy bit and pulses irq_err_o.
- R8: A nonzero length that is not a multiple of 4 sets the direction error (status bit 2 for read, bit 3 for write), sets no chain error and moves no data.
- R9: A cancel command clears both busy bits and drops every memory request by the next cycle. It leaves the error bits unchanged.
- R10: A stop command lets the word copy or descriptor word fetch in progress finish. The engine then halts with both busy bits clear and without pulsing irq_done_o.
- R11: Error bits are sticky. Writing register select 1 clears each error bit whose position (2, 3 or 4) is 1 in the written word, and leaves the others.
- R12: A start for one direction accepted while the other runs keeps its busy bit set. It runs after the first chain ends, and each chain pulses its own irq_done_o.
- R13: A memory request keeps its address stable until acknowledged, and the host and local ports never request together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select: 0 command, 1 error clear, 2 enable, 3 read chain head, 4 write chain head |
| reg_wdata | input | 32 | Register write data |
| status_o | output | 5 | {chain err, write err, read err, write busy, read busy} |
| irq_done_o | output | 1 | One-cycle pulse when a chain completes |
| irq_err_o | output | 1 | One-cycle pulse when a chain is abandoned on an error |
| host_req | output | 1 | Host memory access request |
| host_we | output | 1 | Host access is a write |
| host_addr | output | 32 | Host byte address |
| host_wdata | output | 32 | Host write data |
| host_ack | input | 1 | Host access done; read data valid |
| host_rdata | input | 32 | Host read data |
| loc_req | output | 1 | Local memory access request |
| loc_we | output | 1 | Local access is a write |
| loc_addr | output | 32 | Local byte address |
| loc_wdata | output | 32 | Local write data |
| loc_ack | input | 1 | Local access done; read data valid |
| loc_rdata | input | 32 | Local read data |

## Verification
The hardest states to reach are a stop or a cancel that lands in the middle of a long chain. The bench places a single 32-word descriptor and issues the command a fixed number of cycles after the start, so the engine is certain to be between accesses. It then counts the host writes, which must be more than none and fewer than all. The slot limits come from chains built without a final flag: nine one-word descriptors for the write side and a two-word descriptor for the read side. The hold rule is exercised by slowing the memory models to several wait cycles per access while the bench compares the address on every waiting cycle.

// File: rtl/sg_dma_pkg.sv
// Shared command codes, register selects and engine state type for sg_dma.
package sg_dma_pkg;
    localparam logic [2:0] SEL_CTRL   = 3'd0;
    localparam logic [2:0] SEL_STAT   = 3'd1;
    localparam logic [2:0] SEL_EN     = 3'd2;
    localparam logic [2:0] SEL_RDHEAD = 3'd3;
    localparam logic [2:0] SEL_WRHEAD = 3'd4;

    localparam int CMD_CANCEL = 0;
    localparam int CMD_RD     = 1;
    localparam int CMD_WR     = 2;
    localparam int CMD_STOP   = 4;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH,
        S_CHECK,
        S_SRC,
        S_DST
    } eng_state_t;
endpackage

// File: rtl/sg_dma_regs.sv
// Register file of sg_dma. Holds the enable mask, the two chain head pointers
// and the three sticky error bits, and decodes command writes into pulses.
// Assumes: err_set pulses come from the engine; a set wins over a clear.
module sg_dma_regs
    import sg_dma_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic [2:0]        err_set,
    output logic [2:0]        err_q,
    output logic [DATA_W-1:0] rd_head,
    output logic [DATA_W-1:0] wr_head,
    output logic              cmd_rd,
    output logic              cmd_wr,
    output logic              cmd_cancel,
    output logic              cmd_stop
);
    logic [1:0] enable_q;
    logic       ctrl_wr;
    logic       stat_wr;

    // Decode command writes; starts are gated by the direction enable.
    always_comb begin
        ctrl_wr    = reg_we && (reg_sel == SEL_CTRL);
        stat_wr    = reg_we && (reg_sel == SEL_STAT);
        cmd_cancel = ctrl_wr && (reg_wdata == DATA_W'(CMD_CANCEL));
        cmd_rd     = ctrl_wr && (reg_wdata == DATA_W'(CMD_RD)) && enable_q[0];
        cmd_wr     = ctrl_wr && (reg_wdata == DATA_W'(CMD_WR)) && enable_q[1];
        cmd_stop   = ctrl_wr && (reg_wdata == DATA_W'(CMD_STOP));
    end

    // Plain configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable_q <= '0;
            rd_head  <= '0;
            wr_head  <= '0;
        end else if (reg_we) begin
            if (reg_sel == SEL_EN)     enable_q <= reg_wdata[1:0];
            if (reg_sel == SEL_RDHEAD) rd_head  <= reg_wdata;
            if (reg_sel == SEL_WRHEAD) wr_head  <= reg_wdata;
        end
    end

    // One sticky bit per error kind, cleared by writing 1 at bit i+2.
    for (genvar i = 0; i < 3; i++) begin : g_err
        always_ff @(posedge clk) begin
            if (!rst_n)                          err_q[i] <= 1'b0;
            else if (err_set[i])                 err_q[i] <= 1'b1;
            else if (stat_wr && reg_wdata[i+2])  err_q[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/sg_dma_engine.sv
// Chain walker and word copier of sg_dma. Picks a busy direction (read first),
// fetches three descriptor words, checks the length and copies one word per
// source read plus destination write, then follows the chain.
// Assumes: memory ports acknowledge each held request once; length is bytes.
module sg_dma_engine
    import sg_dma_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int RD_SLOTS = 1,
    parameter int WR_SLOTS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_rd,
    input  logic              cmd_wr,
    input  logic              cmd_cancel,
    input  logic              cmd_stop,
    input  logic [DATA_W-1:0] rd_head,
    input  logic [DATA_W-1:0] wr_head,
    output logic [1:0]        busy,
    output logic [2:0]        err_set,
    output logic              irq_done,
    output logic              irq_err,
    output logic              host_req,
    output logic              host_we,
    output logic [DATA_W-1:0] host_addr,
    output logic [DATA_W-1:0] host_wdata,
    input  logic              host_ack,
    input  logic [DATA_W-1:0] host_rdata,
    output logic              loc_req,
    output logic              loc_we,
    output logic [DATA_W-1:0] loc_addr,
    output logic [DATA_W-1:0] loc_wdata,
    input  logic              loc_ack,
    input  logic [DATA_W-1:0] loc_rdata
);
    localparam int MAX_SLOTS = (WR_SLOTS > RD_SLOTS) ? WR_SLOTS : RD_SLOTS;
    localparam int LW        = $clog2(MAX_SLOTS + 1);
    localparam int BW        = DATA_W - 3;

    eng_state_t         state;
    logic               dir;
    logic               stop_pend;
    logic [DATA_W-1:0]  desc_ptr, w0, w1, w2, src_a, dst_a, data_q;
    logic [1:0]         widx;
    logic [LW-1:0]      link_cnt, lim, next_link;
    logic [BW-1:0]      beats;
    logic               last_f;
    logic [DATA_W-2:0]  len_w;
    logic [DATA_W-1:0]  desc_addr;
    logic               src_ack, dst_ack;

    // Derived values for the current descriptor and direction.
    always_comb begin
        len_w     = w2[DATA_W-2:0];
        lim       = dir ? LW'(WR_SLOTS) : LW'(RD_SLOTS);
        next_link = link_cnt + 1'b1;
        desc_addr = desc_ptr + {{(DATA_W-4){1'b0}}, widx, 2'b00};
        src_ack   = dir ? loc_ack  : host_ack;
        dst_ack   = dir ? host_ack : loc_ack;
    end

    // Bus request generation from the state.
    always_comb begin
        host_req   = (state == S_FETCH) || (state == S_SRC && !dir) || (state == S_DST && dir);
        host_we    = (state == S_DST);
        host_addr  = (state == S_FETCH) ? desc_addr : ((state == S_SRC) ? src_a : dst_a);
        host_wdata = data_q;
        loc_req    = (state == S_SRC && dir) || (state == S_DST && !dir);
        loc_we     = (state == S_DST);
        loc_addr   = (state == S_SRC) ? src_a : dst_a;
        loc_wdata  = data_q;
    end

    // Chain walking state machine with busy, stop and cancel handling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            dir       <= 1'b0;
            busy      <= '0;
            stop_pend <= 1'b0;
            desc_ptr  <= '0;
            w0        <= '0;
            w1        <= '0;
            w2        <= '0;
            src_a     <= '0;
            dst_a     <= '0;
            data_q    <= '0;
            widx      <= '0;
            link_cnt  <= '0;
            beats     <= '0;
            last_f    <= 1'b0;
            err_set   <= '0;
            irq_done  <= 1'b0;
            irq_err   <= 1'b0;
        end else begin
            err_set  <= '0;
            irq_done <= 1'b0;
            irq_err  <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (stop_pend) begin
                        busy      <= '0;
                        stop_pend <= 1'b0;
                    end else if (busy != 2'b00) begin
                        dir      <= !busy[0];
                        desc_ptr <= busy[0] ? rd_head : wr_head;
                        link_cnt <= '0;
                        widx     <= '0;
                        state    <= S_FETCH;
                    end
                end
                S_FETCH: begin
                    if (host_ack) begin
                        case (widx)
                            2'd0:    w0 <= host_rdata;
                            2'd1:    w1 <= host_rdata;
                            default: w2 <= host_rdata;
                        endcase
                        if (stop_pend) begin
                            busy      <= '0;
                            stop_pend <= 1'b0;
                            state     <= S_IDLE;
                        end else if (widx == 2'd2) begin
                            state <= S_CHECK;
                        end else begin
                            widx <= widx + 1'b1;
                        end
                    end
                end
                S_CHECK: begin
                    if (len_w == '0) begin
                        err_set[2] <= 1'b1;
                        busy[dir]  <= 1'b0;
                        irq_err    <= 1'b1;
                        state      <= S_IDLE;
                    end else if (len_w[1:0] != 2'b00) begin
                        err_set[dir] <= 1'b1;
                        busy[dir]    <= 1'b0;
                        irq_err      <= 1'b1;
                        state        <= S_IDLE;
                    end else begin
                        src_a  <= w0;
                        dst_a  <= w1;
                        beats  <= len_w[DATA_W-2:2];
                        last_f <= w2[DATA_W-1];
                        state  <= S_SRC;
                    end
                end
                S_SRC: begin
                    if (src_ack) begin
                        data_q <= dir ? loc_rdata : host_rdata;
                        state  <= S_DST;
                    end
                end
                default: begin
                    if (dst_ack) begin
                        src_a <= src_a + DATA_W'(4);
                        dst_a <= dst_a + DATA_W'(4);
                        beats <= beats - 1'b1;
                        if (beats == BW'(1)) begin
                            if (last_f) begin
                                busy[dir] <= 1'b0;
                                irq_done  <= 1'b1;
                                state     <= S_IDLE;
                            end else if (next_link >= lim) begin
                                err_set[2] <= 1'b1;
                                busy[dir]  <= 1'b0;
                                irq_err    <= 1'b1;
                                state      <= S_IDLE;
                            end else if (stop_pend) begin
                                busy      <= '0;
                                stop_pend <= 1'b0;
                                state     <= S_IDLE;
                            end else begin
                                link_cnt <= next_link;
                                desc_ptr <= desc_ptr + DATA_W'(12);
                                widx     <= '0;
                                state    <= S_FETCH;
                            end
                        end else if (stop_pend) begin
                            busy      <= '0;
                            stop_pend <= 1'b0;
                            state     <= S_IDLE;
                        end else begin
                            state <= S_SRC;
                        end
                    end
                end
            endcase
            if (cmd_stop && busy != 2'b00) stop_pend <= 1'b1;
            if (cmd_rd && !busy[0])        busy[0]   <= 1'b1;
            if (cmd_wr && !busy[1])        busy[1]   <= 1'b1;
            if (cmd_cancel) begin
                state     <= S_IDLE;
                busy      <= '0;
                stop_pend <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/sg_dma.sv
// Top of the descriptor-chain DMA mover: register file plus chain engine.
// Assumes: 32-bit words, byte addresses, descriptors packed 12 bytes apart.
module sg_dma
    import sg_dma_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int RD_SLOTS = 1,
    parameter int WR_SLOTS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [4:0]        status_o,
    output logic              irq_done_o,
    output logic              irq_err_o,
    output logic              host_req,
    output logic              host_we,
    output logic [DATA_W-1:0] host_addr,
    output logic [DATA_W-1:0] host_wdata,
    input  logic              host_ack,
    input  logic [DATA_W-1:0] host_rdata,
    output logic              loc_req,
    output logic              loc_we,
    output logic [DATA_W-1:0] loc_addr,
    output logic [DATA_W-1:0] loc_wdata,
    input  logic              loc_ack,
    input  logic [DATA_W-1:0] loc_rdata
);
    logic [2:0]        err_set, err_q;
    logic [1:0]        busy;
    logic [DATA_W-1:0] rd_head, wr_head;
    logic              cmd_rd, cmd_wr, cmd_cancel, cmd_stop;

    sg_dma_regs #(.DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .err_set(err_set), .err_q(err_q),
        .rd_head(rd_head), .wr_head(wr_head), .cmd_rd(cmd_rd), .cmd_wr(cmd_wr),
        .cmd_cancel(cmd_cancel), .cmd_stop(cmd_stop)
    );

    sg_dma_engine #(.DATA_W(DATA_W), .RD_SLOTS(RD_SLOTS), .WR_SLOTS(WR_SLOTS)) u_eng (
        .clk(clk), .rst_n(rst_n), .cmd_rd(cmd_rd), .cmd_wr(cmd_wr),
        .cmd_cancel(cmd_cancel), .cmd_stop(cmd_stop), .rd_head(rd_head),
        .wr_head(wr_head), .busy(busy), .err_set(err_set), .irq_done(irq_done_o),
        .irq_err(irq_err_o), .host_req(host_req), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_ack(host_ack),
        .host_rdata(host_rdata), .loc_req(loc_req), .loc_we(loc_we),
        .loc_addr(loc_addr), .loc_wdata(loc_wdata), .loc_ack(loc_ack),
        .loc_rdata(loc_rdata)
    );

    // Status view: errors above busy flags.
    assign status_o = {err_q, busy};
endmodule

// File: rtl/sg_dma_checker.sv
// Protocol and status properties for sg_dma, attached by bind.
module sg_dma_checker
    import sg_dma_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic [2:0]        reg_sel,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [4:0]        status_o,
    input logic              irq_done_o,
    input logic              irq_err_o,
    input logic              host_req,
    input logic [DATA_W-1:0] host_addr,
    input logic              host_ack,
    input logic              loc_req,
    input logic [DATA_W-1:0] loc_addr,
    input logic              loc_ack
);
    logic cancel_wr;
    assign cancel_wr = reg_we && (reg_sel == SEL_CTRL) && (reg_wdata == DATA_W'(CMD_CANCEL));

    a_r9_cancel_idle: assert property (@(posedge clk) disable iff (!rst_n)
        cancel_wr |=> (status_o[1:0] == 2'b00 && !host_req && !loc_req));

    a_r13_host_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req && !host_ack && !cancel_wr) |=> (host_req && $stable(host_addr)));

    a_r13_loc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_req && !loc_ack && !cancel_wr) |=> (loc_req && $stable(loc_addr)));

    a_r13_one_port: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_req && loc_req));

    a_r11_chain_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status_o[4]) |-> $past(reg_we && reg_sel == SEL_STAT && reg_wdata[4]));

    a_r5_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        irq_done_o |-> ($past(status_o[1:0]) != 2'b00));

    a_r5_irq_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_done_o && irq_err_o));
endmodule

bind sg_dma sg_dma_checker #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/sg_dma_bench.sv
`timescale 1ns/1ps
module sg_dma_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_sel = '0;
    logic [31:0] reg_wdata = '0;
    logic [4:0]  status_o;
    logic        irq_done_o, irq_err_o;
    logic        host_req, host_we, loc_req, loc_we;
    logic [31:0] host_addr, host_wdata, loc_addr, loc_wdata;
    logic        host_ack = 1'b0, loc_ack = 1'b0;
    logic [31:0] host_rdata = '0, loc_rdata = '0;

    sg_dma u_sg_dma (.*);

    always #2.5 clk = ~clk;

    logic [31:0] hmem [0:255];
    logic [31:0] lmem [0:255];
    int n_chk = 0, n_fail = 0, cyc = 0;
    int lat = 0;
    int hwait = 0, lwait = 0, hold_bad = 0;
    int host_acc = 0, host_wr = 0, n_done = 0, n_err = 0;
    logic [31:0] h_a0, l_a0;
    int bk_seq = 0, bk_seen = 0, bk_tgt = 0, bk_idx = 0;
    logic [31:0] bk_dat = '0;

    function automatic logic [31:0] lp(int i); return 32'hC000_0000 | i; endfunction
    function automatic logic [31:0] hp(int i); return 32'h3000_0000 | i; endfunction

    // Memory models and interrupt monitor, all sampled on the falling edge.
    always @(negedge clk) begin
        host_ack <= 1'b0;
        loc_ack  <= 1'b0;
        if (irq_done_o) n_done <= n_done + 1;
        if (irq_err_o)  n_err  <= n_err + 1;
        if (bk_seq != bk_seen) begin
            bk_seen <= bk_seq;
            if (bk_tgt != 0) lmem[bk_idx] <= bk_dat; else hmem[bk_idx] <= bk_dat;
        end
        if (host_req && !host_ack) begin
            if (hwait == 0) h_a0 <= host_addr;
            else if (host_addr != h_a0) hold_bad <= hold_bad + 1;
            if (hwait >= lat) begin
                hwait    <= 0;
                host_ack <= 1'b1;
                host_acc <= host_acc + 1;
                if (host_we) begin
                    hmem[host_addr[9:2]] <= host_wdata;
                    host_wr <= host_wr + 1;
                end else host_rdata <= hmem[host_addr[9:2]];
            end else hwait <= hwait + 1;
        end else if (!host_req) hwait <= 0;
        if (loc_req && !loc_ack) begin
            if (lwait == 0) l_a0 <= loc_addr;
            else if (loc_addr != l_a0) hold_bad <= hold_bad + 1;
            if (lwait >= lat) begin
                lwait   <= 0;
                loc_ack <= 1'b1;
                if (loc_we) lmem[loc_addr[9:2]] <= loc_wdata;
                else loc_rdata <= lmem[loc_addr[9:2]];
            end else lwait <= lwait + 1;
        end else if (!loc_req) lwait <= 0;
    end

    // Watchdog: a hung run is reported as a failed check.
    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            $display("FAIL watchdog expired act=%0d exp=<150000", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 1);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic poke(input int tgt, input int idx, input logic [31:0] dat);
        @(negedge clk);
        bk_tgt = tgt; bk_idx = idx; bk_dat = dat; bk_seq = bk_seq + 1;
        @(negedge clk);
    endtask

    task automatic desc(input int byte_a, input logic [31:0] a, input logic [31:0] b, input logic [31:0] c);
        poke(0, byte_a / 4, a);
        poke(0, byte_a / 4 + 1, b);
        poke(0, byte_a / 4 + 2, c);
    endtask

    task automatic wreg(input logic [2:0] sel, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 3000 && status_o[1:0] != 2'b00; i++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        chk(status_o == 5'd0, "R1 status", 32'(status_o), 0);
        chk(!host_req && !loc_req, "R1 requests", {host_req, loc_req}, 0);
        chk(!irq_done_o && !irq_err_o, "R1 irqs", {irq_done_o, irq_err_o}, 0);
    endtask

    task automatic t_write_single();
        int d0 = n_done;
        wreg(3'd2, 32'd3);
        desc(32'h000, 32'h040, 32'h200, 32'h8000_0010);
        wreg(3'd4, 32'h000);
        wreg(3'd0, 32'd2);
        chk(status_o[1] == 1'b1, "R2 write busy after start", 32'(status_o), 32'h2);
        wait_idle();
        for (int i = 0; i < 4; i++)
            chk(hmem[128 + i] == lp(16 + i), "R3 single descriptor word", hmem[128 + i], lp(16 + i));
        chk(n_done == d0 + 1 && status_o == 5'd0, "R5 done pulse and idle", 32'(n_done - d0), 1);
    endtask

    task automatic t_write_chain();
        int d0 = n_done;
        desc(32'h010, 32'h060, 32'h240, 32'h0000_0008);
        desc(32'h01C, 32'h080, 32'h260, 32'h8000_0004);
        wreg(3'd4, 32'h010);
        wreg(3'd0, 32'd2);
        wait_idle();
        chk(hmem[144] == lp(24) && hmem[145] == lp(25), "R3 first link", hmem[145], lp(25));
        chk(hmem[152] == lp(32), "R3 second link at +12", hmem[152], lp(32));
        chk(hmem[146] == hp(146), "R3 no overrun", hmem[146], hp(146));
        chk(n_done == d0 + 1, "R5 one done per chain", 32'(n_done - d0), 1);
    endtask

    task automatic t_read();
        desc(32'h030, 32'h280, 32'h200, 32'h8000_000C);
        wreg(3'd3, 32'h030);
        wreg(3'd0, 32'd1);
        chk(status_o[0] == 1'b1, "R2 read busy after start", 32'(status_o), 1);
        wait_idle();
        for (int i = 0; i < 3; i++)
            chk(lmem[128 + i] == hp(160 + i), "R4 read copy", lmem[128 + i], hp(160 + i));
    endtask

    task automatic t_disabled();
        int a0;
        wreg(3'd2, 32'd0);
        a0 = host_acc;
        wreg(3'd0, 32'd1);
        chk(status_o[1:0] == 2'b00, "R2 disabled start ignored", 32'(status_o), 0);
        repeat (10) @(negedge clk);
        chk(host_acc == a0, "R2 no access when disabled", 32'(host_acc - a0), 0);
        wreg(3'd2, 32'd3);
    endtask

    task automatic t_zero_len();
        int e0 = n_err, w0 = host_wr;
        desc(32'h040, 32'h0A0, 32'h2A0, 32'h8000_0000);
        wreg(3'd4, 32'h040);
        wreg(3'd0, 32'd2);
        wait_idle();
        chk(status_o == 5'b10000, "R7 zero length chain error", 32'(status_o), 32'h10);
        chk(n_err == e0 + 1 && host_wr == w0, "R7 irq and no data", 32'(host_wr - w0), 0);
        wreg(3'd1, 32'h08);
        chk(status_o[4] == 1'b1, "R11 other bit kept", 32'(status_o), 32'h10);
        wreg(3'd1, 32'h10);
        chk(status_o == 5'd0, "R11 clear chain error", 32'(status_o), 0);
    endtask

    task automatic t_misaligned();
        int w0 = host_wr;
        desc(32'h050, 32'h0A0, 32'h2A0, 32'h8000_0006);
        wreg(3'd4, 32'h050);
        wreg(3'd0, 32'd2);
        wait_idle();
        chk(status_o == 5'b01000, "R8 write direction error", 32'(status_o), 32'h08);
        chk(host_wr == w0, "R8 no data moved", 32'(host_wr - w0), 0);
        wreg(3'd1, 32'h1C);
    endtask

    task automatic t_wr_limit();
        int w0 = host_wr, e0 = n_err;
        for (int i = 0; i < 9; i++) desc(32'h060 + 12 * i, 32'h0C0 + 4 * i, 32'h300 + 4 * i, 32'h4);
        wreg(3'd4, 32'h060);
        wreg(3'd0, 32'd2);
        wait_idle();
        chk(host_wr == w0 + 8, "R6 eight write links", 32'(host_wr - w0), 8);
        chk(status_o == 5'b10000 && n_err == e0 + 1, "R6 write slot limit error", 32'(status_o), 32'h10);
        chk(hmem[199] == lp(55) && hmem[200] == hp(200), "R6 ninth not copied", hmem[200], hp(200));
        wreg(3'd1, 32'h1C);
    endtask

    task automatic t_rd_limit();
        desc(32'h0D0, 32'h2C0, 32'h240, 32'h8);
        wreg(3'd3, 32'h0D0);
        wreg(3'd0, 32'd1);
        wait_idle();
        chk(lmem[144] == hp(176) && lmem[145] == hp(177), "R6 read link copied", lmem[145], hp(177));
        chk(status_o == 5'b10000, "R6 read slot limit error", 32'(status_o), 32'h10);
        wreg(3'd1, 32'h1C);
    endtask

    task automatic t_queue();
        int d0 = n_done;
        desc(32'h0E0, 32'h100, 32'h380, 32'h8000_0020);
        wreg(3'd4, 32'h0E0);
        wreg(3'd3, 32'h030);
        wreg(3'd0, 32'd2);
        wreg(3'd0, 32'd1);
        chk(status_o[1:0] == 2'b11, "R12 both busy", 32'(status_o), 3);
        wait_idle();
        chk(n_done == d0 + 2, "R12 two done pulses", 32'(n_done - d0), 2);
        chk(hmem[231] == lp(71) && lmem[130] == hp(162), "R12 both copied", hmem[231], lp(71));
    endtask

    task automatic t_hold();
        lat = 3;
        poke(1, 16, 32'hDEAD_0001);
        wreg(3'd4, 32'h000);
        wreg(3'd0, 32'd2);
        wait_idle();
        chk(hold_bad == 0, "R13 address stable while waiting", 32'(hold_bad), 0);
        chk(hmem[128] == 32'hDEAD_0001, "R13 slow memory copy", hmem[128], 32'hDEAD_0001);
        lat = 0;
    endtask

    task automatic t_stop();
        int w0 = host_wr, d0 = n_done;
        desc(32'h0F0, 32'h140, 32'h200, 32'h8000_0080);
        wreg(3'd4, 32'h0F0);
        wreg(3'd0, 32'd2);
        repeat (12) @(negedge clk);
        wreg(3'd0, 32'd4);
        repeat (10) @(negedge clk);
        chk(status_o == 5'd0, "R10 halted and idle", 32'(status_o), 0);
        chk(host_wr > w0 && host_wr < w0 + 32, "R10 partial copy", 32'(host_wr - w0), 32'd16);
        chk(n_done == d0, "R10 no done pulse", 32'(n_done - d0), 0);
    endtask

    task automatic t_cancel();
        desc(32'h040, 32'h0A0, 32'h2A0, 32'h8000_0000);
        wreg(3'd4, 32'h040);
        wreg(3'd0, 32'd2);
        wait_idle();
        wreg(3'd4, 32'h0F0);
        wreg(3'd0, 32'd2);
        repeat (8) @(negedge clk);
        wreg(3'd0, 32'd0);
        chk(status_o[1:0] == 2'b00, "R9 busy cleared at once", 32'(status_o), 32'h10);
        chk(!host_req && !loc_req, "R9 requests dropped", {host_req, loc_req}, 0);
        chk(status_o[4] == 1'b1, "R9 error kept", 32'(status_o), 32'h10);
        repeat (3) @(negedge clk);
        wreg(3'd1, 32'h1C);
        chk(status_o == 5'd0, "R11 clear after cancel", 32'(status_o), 0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            poke(0, i, hp(i));
            poke(1, i, lp(i));
        end
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write_single();
        t_write_chain();
        t_read();
        t_disabled();
        t_zero_len();
        t_misaligned();
        t_wr_limit();
        t_rd_limit();
        t_queue();
        t_hold();
        t_stop();
        t_cancel();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule